// File: doc/BRIEF.md
# Duplicate-Tag Invalidation Directory Slice

This block sits next to one bank of a shared second-level cache and holds a shadow copy of the tag array of every core's private first-level data cache. Those caches write through to the shared level, allocate lines only on read misses and never on writes, so the shadow copy changes only on two events: a read-miss fill, which records a tag, and an eviction, which drops one. Instead of a sharer list on every shared line, the slice finds sharers by searching the shadow copies at the first-level set index.

When a store from one core reaches this bank, the slice reads every core's copy at the store's set, compares the tags and sends one invalidate to each other core that holds the line. The storing core is skipped, because its own write-through cache stays current. Invalidates leave one at a time over a valid/ready channel, and the slice takes no new request until the last one has been accepted. Each accepted invalidate also clears the target's shadow entry. One slice is built per bank. A request whose bank field names another bank has no effect here.

Top module: `dup_tag_dir`

## Requirements
- R1: After synchronous reset `req_ready` is 1, `inv_valid` is 0 and every shadow entry of every core is invalid, so a store finds no sharer.
- R2: `req_line` is split as bank = bits [1:0], set index = the next log2(L1_SETS) bits, tag = the remaining upper bits. A fill (`req_op` = 0) records the tag as valid for `req_core` at that set and does not stall the request channel.
- R3: A store (`req_op` = 2) sends an invalidate to every core other than `req_core` whose valid shadow entry at the store's set holds the store's tag, and never to `req_core`.
- R4: The invalidates of one store are issued in ascending core index, and each carries the store's full line address on `inv_line`.
- R5: While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid`, `inv_core` and `inv_line` hold their values.
- R6: `req_ready` is 0 from the cycle after a store is accepted until the cycle after its last invalidate is accepted. A store that finds no sharer holds `req_ready` low for exactly one cycle.
- R7: An eviction (`req_op` = 1) invalidates the shadow entry of `req_core` at the set index, whatever tag it holds.
- R8: An accepted invalidate clears the target core's shadow entry, so a repeated store to the same line sends nothing to that core.
- R9: A request whose bank field differs from `BANK_ID`, or whose `req_op` is 3, is accepted and changes no shadow entry and sends no invalidate.
- R10: A store whose tag differs from a core's valid entry at the same set sends that core nothing. A fill overwrites the tag held earlier at its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can accept a request |
| req_op | input | 2 | 0 fill, 1 evict, 2 store, 3 no operation |
| req_core | input | log2(NUM_CORES) | Originating core |
| req_line | input | LINE_W | Cache line address |
| inv_valid | output | 1 | Invalidate message present |
| inv_ready | input | 1 | Receiver takes the invalidate |
| inv_core | output | log2(NUM_CORES) | Core to invalidate |
| inv_line | output | LINE_W | Line to invalidate |

## Verification
The bench targets a store by a core that is itself a sharer, where all seven other cores hold the line. A design that did not exclude the requester would send eight messages, and one that ordered the messages wrongly would fail the ascending-index comparison. It applies random `inv_ready` back-pressure, under which a design that advanced its pending set without a handshake would drop targets. It repeats a store after invalidation, evicts with a mismatching tag, overwrites a set with a new tag and issues wrong-bank and no-operation requests. A design that failed to clear entries would send stale invalidates, one that compared tags on eviction would leave a live sharer, and one that ignored the bank field would record foreign lines.

// File: rtl/dup_tag_dir_pkg.sv
package dup_tag_dir_pkg;
  // Request opcodes carried on req_op
  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_EVICT = 2'd1,
    OP_STORE = 2'd2,
    OP_NOP   = 2'd3
  } dtd_op_e;

  // Slice sequencing
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_SEND   = 2'd2
  } dtd_state_e;
endpackage

// File: rtl/dtd_tag_ram.sv
// Per-core shadow tag store: one write port, one registered read port,
// no reset, so it maps onto block RAM.
module dtd_tag_ram #(
  parameter int SETS  = 64,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  logic [TAG_W-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_tag <= mem[rd_idx];
  end
endmodule

// File: rtl/dtd_valid_array.sv
// Presence bits for the shadow tags. Kept in flops so that reset clears
// them in one cycle and every core's bit can be read combinationally.
module dtd_valid_array #(
  parameter int CORES = 8,
  parameter int SETS  = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int CORE_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [CORE_W-1:0] set_core,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr_en,
  input  logic [CORE_W-1:0] clr_core,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CORES-1:0]  rd_vec
);
  logic [SETS-1:0] vld_q [CORES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CORES; c++) vld_q[c] <= '0;
    end else begin
      if (set_en) vld_q[set_core][set_idx] <= 1'b1;
      if (clr_en) vld_q[clr_core][clr_idx] <= 1'b0;
    end
  end

  for (genvar c = 0; c < CORES; c++) begin : g_rd
    assign rd_vec[c] = vld_q[c][rd_idx];
  end

  // Fills and clears come from different phases of the slice
  assert_set_clr_apart_R2: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/dtd_inv_sched.sv
// Holds the set of cores still owed an invalidate and presents them one
// at a time, lowest index first, on a registered valid/ready output.
module dtd_inv_sched #(
  parameter int CORES  = 8,
  parameter int LINE_W = 24,
  localparam int CORE_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CORES-1:0]  load_mask,
  input  logic [LINE_W-1:0] load_line,
  input  logic              inv_ready,
  output logic              inv_valid,
  output logic [CORE_W-1:0] inv_core,
  output logic [LINE_W-1:0] inv_line,
  output logic              fire,
  output logic              fire_last
);
  logic [CORES-1:0] pend_q;

  function automatic logic [CORE_W-1:0] pick_low(input logic [CORES-1:0] m);
    pick_low = '0;
    for (int i = CORES - 1; i >= 0; i--) begin
      if (m[i]) pick_low = CORE_W'(i);
    end
  endfunction

  function automatic logic [CORES-1:0] drop_bit(input logic [CORES-1:0] m,
                                                 input logic [CORE_W-1:0] i);
    drop_bit = m & ~({{(CORES-1){1'b0}}, 1'b1} << i);
  endfunction

  assign fire      = inv_valid && inv_ready;
  assign fire_last = fire && (pend_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_valid <= 1'b0;
      inv_core  <= '0;
      inv_line  <= '0;
      pend_q    <= '0;
    end else if (load) begin
      inv_line <= load_line;
      if (load_mask != '0) begin
        inv_valid <= 1'b1;
        inv_core  <= pick_low(load_mask);
        pend_q    <= drop_bit(load_mask, pick_low(load_mask));
      end
    end else if (fire) begin
      if (pend_q != '0) begin
        inv_core <= pick_low(pend_q);
        pend_q   <= drop_bit(pend_q, pick_low(pend_q));
      end else begin
        inv_valid <= 1'b0;
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_core) && $stable(inv_line)));
endmodule

// File: rtl/dup_tag_dir.sv
// One directory slice: shadow L1 tags for all cores, searched on stores
// that reach this bank.
module dup_tag_dir
  import dup_tag_dir_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int L1_SETS   = 64,
  parameter int LINE_W    = 24,
  parameter int NUM_BANKS = 4,
  parameter int BANK_ID   = 0,
  localparam int CORE_W    = $clog2(NUM_CORES),
  localparam int IDX_W     = $clog2(L1_SETS),
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int TAG_W     = LINE_W - BANK_BITS - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CORE_W-1:0] req_core,
  input  logic [LINE_W-1:0] req_line,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [CORE_W-1:0] inv_core,
  output logic [LINE_W-1:0] inv_line
);
  // Address fields
  logic [BANK_BITS-1:0] req_bank;
  logic [IDX_W-1:0]     req_idx;
  logic [TAG_W-1:0]     req_tag;
  assign req_bank = req_line[BANK_BITS-1:0];
  assign req_idx  = req_line[BANK_BITS +: IDX_W];
  assign req_tag  = req_line[LINE_W-1 -: TAG_W];

  dtd_state_e state_q;
  dtd_op_e    op;
  logic       accept, bank_ok;
  logic       do_fill, do_evict, do_store;

  assign op        = dtd_op_e'(req_op);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bank_ok   = (req_bank == BANK_BITS'(BANK_ID));
  assign do_fill   = accept && bank_ok && (op == OP_FILL);
  assign do_evict  = accept && bank_ok && (op == OP_EVICT);
  assign do_store  = accept && bank_ok && (op == OP_STORE);

  // Captured store
  logic [CORE_W-1:0] st_core;
  logic [IDX_W-1:0]  st_idx;
  logic [TAG_W-1:0]  st_tag;
  logic [LINE_W-1:0] st_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_core <= '0;
      st_idx  <= '0;
      st_tag  <= '0;
      st_line <= '0;
    end else if (do_store) begin
      st_core <= req_core;
      st_idx  <= req_idx;
      st_tag  <= req_tag;
      st_line <= req_line;
    end
  end

  // Shadow tag arrays, one per core
  logic [TAG_W-1:0] ram_tag [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    dtd_tag_ram #(
      .SETS  (L1_SETS),
      .TAG_W (TAG_W)
    ) tag_ram_i (
      .clk    (clk),
      .wr_en  (do_fill && (req_core == CORE_W'(c))),
      .wr_idx (req_idx),
      .wr_tag (req_tag),
      .rd_en  (do_store),
      .rd_idx (req_idx),
      .rd_tag (ram_tag[c])
    );
  end

  // Presence bits
  logic              fire, fire_last;
  logic              clr_en;
  logic [CORE_W-1:0] clr_core;
  logic [IDX_W-1:0]  clr_idx;
  logic [NUM_CORES-1:0] vld_rd;

  assign clr_en   = do_evict || fire;
  assign clr_core = fire ? inv_core : req_core;
  assign clr_idx  = fire ? st_idx : req_idx;

  dtd_valid_array #(
    .CORES (NUM_CORES),
    .SETS  (L1_SETS)
  ) valid_i (
    .clk      (clk),
    .rst      (rst),
    .set_en   (do_fill),
    .set_core (req_core),
    .set_idx  (req_idx),
    .clr_en   (clr_en),
    .clr_core (clr_core),
    .clr_idx  (clr_idx),
    .rd_idx   (st_idx),
    .rd_vec   (vld_rd)
  );

  // Sharer search, valid during the lookup cycle
  logic [NUM_CORES-1:0] match;
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_match
    assign match[c] = vld_rd[c] && (ram_tag[c] == st_tag) &&
                      (st_core != CORE_W'(c));
  end

  dtd_inv_sched #(
    .CORES  (NUM_CORES),
    .LINE_W (LINE_W)
  ) sched_i (
    .clk       (clk),
    .rst       (rst),
    .load      (state_q == ST_LOOKUP),
    .load_mask (match),
    .load_line (st_line),
    .inv_ready (inv_ready),
    .inv_valid (inv_valid),
    .inv_core  (inv_core),
    .inv_line  (inv_line),
    .fire      (fire),
    .fire_last (fire_last)
  );

  // Sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (do_store) state_q <= ST_LOOKUP;
        ST_LOOKUP: state_q <= (match != '0) ? ST_SEND : ST_IDLE;
        ST_SEND:   if (fire_last) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assert_skip_requester_R3: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_core != st_core));
  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);
  assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |=> (!inv_valid || (inv_core > $past(inv_core))));
  assert_line_R4: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_line == st_line));
endmodule

// File: tb/dup_tag_dir_tb_top.sv
module dup_tag_dir_tb_top;
  localparam int NC = 8;
  localparam int SETS = 64;
  localparam int LW = 24;
  localparam int NB = 4;
  localparam int BID = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [CW-1:0] req_core = '0;
  logic [LW-1:0] req_line = '0;
  logic inv_valid;
  logic inv_ready = 1'b0;
  logic [CW-1:0] inv_core;
  logic [LW-1:0] inv_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit        mv [NC][SETS];
  bit [15:0] mt [NC][SETS];

  always #10 clk = ~clk;

  dup_tag_dir #(
    .NUM_CORES (NC),
    .L1_SETS   (SETS),
    .LINE_W    (LW),
    .NUM_BANKS (NB),
    .BANK_ID   (BID)
  ) dut_i (
    .clk, .rst, .req_valid, .req_ready, .req_op, .req_core, .req_line,
    .inv_valid, .inv_ready, .inv_core, .inv_line
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(int tag, int idx, int bank);
    return {tag[15:0], idx[5:0], bank[1:0]};
  endfunction

  task automatic issue(int op, int core, logic [LW-1:0] line);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op[1:0];
    req_core  = core[CW-1:0];
    req_line  = line;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_op(int op, int core, logic [LW-1:0] line, string rq);
    int bank = int'(line[1:0]);
    int idx  = int'(line[7:2]);
    bit [15:0] tag = line[23:8];
    issue(op, core, line);
    if (bank != BID || op == 3 || op == 0 || op == 1) begin
      if (bank == BID && op == 0) begin mv[core][idx] = 1; mt[core][idx] = tag; end
      if (bank == BID && op == 1) mv[core][idx] = 0;
      @(negedge clk);
      chk(req_ready && !inv_valid, rq, int'({req_ready, inv_valid}), 2);
    end else begin
      int exp_c[NC];
      int n = 0;
      int k = 0;
      int busy = 0;
      for (int c = 0; c < NC; c++)
        if (c != core && mv[c][idx] && mt[c][idx] == tag) begin exp_c[n] = c; n++; end
      forever begin
        @(negedge clk);
        if (req_ready) break;
        busy++;
        if (inv_valid) begin
          inv_ready = ($urandom % 3) != 0;
          if (inv_ready) begin
            chk(k < n && int'(inv_core) == exp_c[k], {rq, " R3 R4 target"},
                int'(inv_core), (k < n) ? exp_c[k] : -1);
            chk(inv_line == line, "R4 line", int'(inv_line), int'(line));
            k++;
          end
        end else inv_ready = 1'b0;
      end
      inv_ready = 1'b0;
      chk(k == n, {rq, " R3 count"}, k, n);
      if (n == 0) chk(busy == 1, "R6 no-sharer stall", busy, 1);
      for (int j = 0; j < n; j++) mv[exp_c[j]][idx] = 0;
    end
  endtask

  initial begin
    logic [LW-1:0] l0, l1;
    void'($urandom(32'h5EED1));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(inv_valid == 1'b0, "R1 inv_valid", int'(inv_valid), 0);

    l0 = mk(16'h12, 5, BID);
    l1 = mk(16'h34, 5, BID);
    do_op(2, 0, l0, "R1 empty");
    for (int c = 0; c < NC; c++) do_op(0, c, l0, "R2 fill");
    do_op(2, 3, l0, "R3 all sharers");
    do_op(2, 3, l0, "R8 repeat");
    do_op(0, 1, l0, "R2 fill");
    do_op(0, 5, l0, "R2 fill");
    do_op(1, 1, l1, "R7 evict");
    do_op(2, 0, l0, "R7 after evict");
    do_op(0, 2, l1, "R10 fill other tag");
    do_op(0, 4, l0, "R2 fill");
    do_op(0, 4, l1, "R10 overwrite");
    do_op(2, 6, l0, "R10 tag miss");
    do_op(2, 6, l1, "R10 new tag");
    do_op(0, 7, mk(16'h12, 5, 1), "R9 wrong bank");
    do_op(2, 0, mk(16'h12, 5, 1), "R9 wrong bank");
    do_op(3, 7, l0, "R9 nop");
    do_op(2, 0, l0, "R9 after ignored");

    for (int i = 0; i < 800; i++) begin
      int r = $urandom % 100;
      int op = (r < 40) ? 0 : (r < 55) ? 1 : (r < 92) ? 2 : 3;
      int bank = (($urandom % 20) == 0) ? (BID + 1) % NB : BID;
      do_op(op, $urandom % NC,
            mk($urandom % 3, $urandom % 4, bank), "R3 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule